// File: doc/BRIEF.md
# Staged-commit register front end for a real-time clock

This block sits between a simple 32-bit memory-mapped bus and the slow time-keeping domain of a real-time clock. Bus writes land in holding registers and move into the time-keeping image only when software writes a commit trigger. While the transfer is in progress a busy flag reads 1. The clock-domain crossing is modelled as a fixed latency of `COMMIT_LAT` cycles. Writes that arrive during a commit are stalled with `bus_wait` rather than dropped.

Three guards limit what software can change. A protection word must be committed twice: first with 0x9136, then with 0x586A. Only after that do the time-set, alarm and interrupt-enable registers accept writes. Control writes act only when they carry a key byte. The two power-key registers accept writes only after both configuration registers have been written and committed. Until the committed power keys hold their constants, the block reports a power-lost condition.

The commit sequencer has three states. `SQ_IDLE` goes to `SQ_WAIT` on an accepted trigger. `SQ_WAIT` goes to `SQ_APPLY` when its down-counter reaches zero. `SQ_APPLY` copies the staged words and returns to `SQ_IDLE`. The unlock machine evaluates a protection word only at a commit and only if that word was written since the last commit. Its transitions are:
- `UL_LOCKED` goes to `UL_HALF` on 0x9136.
- `UL_HALF` goes to `UL_OPEN` on 0x586A.
- `UL_OPEN` goes to `UL_HALF` on 0x9136.
- Any other value returns to `UL_LOCKED`.

Top module: `rtcf_commit_if`

## Requirements
- R1: While idle, a write of exactly 32'h1 to byte offset 0x78 starts a commit, and bit 6 of a read at offset 0x00 is 1 in the following cycle. A trigger write of any other value, or any trigger write while busy, is ignored.
- R2: The busy bit stays 1 for exactly COMMIT_LAT+1 cycles and then returns to 0. From that cycle on, `dom_image` (word i at bits i*16+15:i*16) equals the staged words, and `dom_load` is 1 for that single cycle. `dom_image` changes at no other time except through R3's power-key clear.
- R3: A write at offset 0x00 acts only when write bits 15:8 equal 0x43. With the key, bit 5 gives a one-cycle `tk_reload` pulse in the next cycle, and bit 4 clears the staged and committed power-key words at once. Without the key, neither happens.
- R4: After 0x9136 is written at offset 0x70 and committed, and then 0x586A is written and committed, `if_unlocked` reads 1. After the first of these two commits alone it still reads 0.
- R5: A committed protection word other than the expected next one makes `if_unlocked` 0 and restarts the sequence. Committing 0x9136 while unlocked also drops `if_unlocked` to 0.
- R6: While `if_unlocked` is 0, writes to the guarded words are ignored. These are offset 0x08 (interrupt enable), 0x10 (alarm mask), 0x14 to 0x2C (time set) and 0x30 to 0x48 (alarm).
- R7: `power_lost` is 1 unless committed word 19 (offset 0x4C) equals 0xA357 and committed word 20 (offset 0x50) equals 0x67D2. Writing the keys without committing them leaves `power_lost` at 1.
- R8: Writes to 0x4C and 0x50 are ignored until both configuration words (0x5C and 0x60) have been written and a commit has completed after that.
- R9: A write to any implemented offset other than 0x78 while busy raises `bus_wait`. It is held until the commit ends, then accepted, and it is not part of that commit.
- R10: A read of a staged offset returns its last accepted 16-bit value, zero-extended. A read at 0x14 + 4k (k = 0..6) returns byte k of `tk_live`. Unimplemented offsets read 0.
- R11: After reset, busy is 0, `if_unlocked` is 0, `power_lost` is 1 and every staged and committed word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write request, held until `bus_wait` is low |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| bus_wait | output | 1 | Stall for a write during a commit |
| tk_live | input | 56 | Live time counter, one byte per field |
| dom_image | output | NW*DW | Committed register image seen by the time-keeping domain |
| dom_load | output | 1 | One-cycle pulse when a new image is valid |
| tk_reload | output | 1 | One-cycle reload request |
| power_lost | output | 1 | Committed power keys do not match |
| if_unlocked | output | 1 | Guarded registers accept writes |

## Verification
The assertions assume that a master keeps `bus_wr`, `bus_addr` and `bus_wdata` steady while `bus_wait` is high. They also assume that `tk_live` is quiet around a read. The bench drives every write through a single task that holds the request until the stall drops, and it changes `tk_live` only between reads. Random values go only into the data fields. Offsets are drawn from the guarded set, so that the unlock, key-order and stall rules are reached in a known order.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;
    localparam int unsigned NW = 32;
    localparam int unsigned DW = 16;

    localparam int unsigned IX_CTRL   = 0;
    localparam int unsigned IX_IRQEN  = 2;
    localparam int unsigned IX_AMASK  = 4;
    localparam int unsigned IX_TIME0  = 5;
    localparam int unsigned IX_TIME_N = 11;
    localparam int unsigned IX_ALM_N  = 18;
    localparam int unsigned IX_PK1    = 19;
    localparam int unsigned IX_PK2    = 20;
    localparam int unsigned IX_CFG0   = 23;
    localparam int unsigned IX_CFG1   = 24;
    localparam int unsigned IX_PROT   = 28;
    localparam int unsigned IX_TRIG   = 30;

    localparam logic [7:0]    CTRL_KEY = 8'h43;
    localparam logic [DW-1:0] PROT_K1  = 16'h9136;
    localparam logic [DW-1:0] PROT_K2  = 16'h586A;
    localparam logic [DW-1:0] PK1_VAL  = 16'hA357;
    localparam logic [DW-1:0] PK2_VAL  = 16'h67D2;

    typedef enum logic [2:0] {
        RK_NONE, RK_CTRL, RK_GUARD, RK_TIME, RK_PKEY, RK_CFG, RK_PROT, RK_TRIG
    } rk_e;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_APPLY} sq_e;
    typedef enum logic [1:0] {UL_LOCKED, UL_HALF, UL_OPEN} ul_e;

    function automatic rk_e reg_kind(input logic [4:0] ix);
        int unsigned n;
        n = int'(ix);
        if (n == IX_CTRL)                            return RK_CTRL;
        if (n == IX_IRQEN || n == IX_AMASK)          return RK_GUARD;
        if (n >= IX_TIME0 && n <= IX_TIME_N)         return RK_TIME;
        if (n > IX_TIME_N && n <= IX_ALM_N)          return RK_GUARD;
        if (n == IX_PK1 || n == IX_PK2)              return RK_PKEY;
        if (n == IX_CFG0 || n == IX_CFG1)            return RK_CFG;
        if (n == IX_PROT)                            return RK_PROT;
        if (n == IX_TRIG)                            return RK_TRIG;
        return RK_NONE;
    endfunction
endpackage

// File: rtl/rtcf_commit_seq.sv
module rtcf_commit_seq
    import rtcf_pkg::*;
#(
    parameter int unsigned LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic apply
);
    localparam int unsigned CW = $clog2(LAT + 1);

    sq_e           st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (start) begin
                    st_d  = SQ_WAIT;
                    cnt_d = CW'(LAT - 1);
                end
            end
            SQ_WAIT: begin
                if (cnt_q == '0) st_d = SQ_APPLY;
                else             cnt_d = cnt_q - 1'b1;
            end
            SQ_APPLY: st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        busy  = (st_q != SQ_IDLE);
        apply = (st_q == SQ_APPLY);
    end

    // R2: a copy happens in one cycle only, then the sequencer is idle
    a_r2_apply_single: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !busy);
    // R1: a start is taken only from idle and always leads to waiting
    a_r1_start_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (st_q == SQ_WAIT));
endmodule

// File: rtl/rtcf_unlock.sv
module rtcf_unlock
    import rtcf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic          dirty,
    input  logic [DW-1:0] val,
    output logic          open
);
    ul_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (apply && dirty) begin
            unique case (st_q)
                UL_LOCKED: st_d = (val == PROT_K1) ? UL_HALF : UL_LOCKED;
                UL_HALF:   st_d = (val == PROT_K2) ? UL_OPEN : UL_LOCKED;
                UL_OPEN:   st_d = (val == PROT_K1) ? UL_HALF : UL_LOCKED;
                default:   st_d = UL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UL_LOCKED;
        else        st_q <= st_d;
    end

    always_comb open = (st_q == UL_OPEN);

    // R4: the open state is reachable only from the half-way state
    a_r4_open_from_half: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UL_OPEN && $past(st_q) != UL_OPEN) |-> $past(st_q) == UL_HALF);
    // R5: a committed foreign word always restarts the sequence
    a_r5_wrong_word_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && dirty && val != PROT_K1 && val != PROT_K2) |=> st_q == UL_LOCKED);
endmodule

// File: rtl/rtcf_regfile.sv
module rtcf_regfile
    import rtcf_pkg::*;
#(
    parameter int unsigned IW = $clog2(NW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [DW-1:0]          wr_data,
    input  logic                   apply,
    input  logic                   clr_pk,
    output logic [NW-1:0][DW-1:0]  stage_o,
    output logic [NW-1:0][DW-1:0]  dom_o
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam rk_e K = reg_kind(5'(i));
        if (K == RK_NONE || K == RK_CTRL || K == RK_TRIG) begin : g_tie
            assign stage_o[i] = '0;
            assign dom_o[i]   = '0;
        end else begin : g_ff
            logic [DW-1:0] stg_q, dom_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                    dom_q <= '0;
                end else begin
                    if (wr_en && wr_idx == IW'(i))       stg_q <= wr_data;
                    else if (clr_pk && K == RK_PKEY)     stg_q <= '0;
                    if (apply)                           dom_q <= stg_q;
                    else if (clr_pk && K == RK_PKEY)     dom_q <= '0;
                end
            end
            assign stage_o[i] = stg_q;
            assign dom_o[i]   = dom_q;
        end
    end

    // R2: the committed image moves only on a copy or a power-key clear
    a_r2_dom_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !clr_pk) |=> $stable(dom_o));
endmodule

// File: rtl/rtcf_commit_if.sv
module rtcf_commit_if
    import rtcf_pkg::*;
#(
    parameter int unsigned COMMIT_LAT = 8,
    parameter int unsigned AW         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_wait,
    input  logic [55:0]       tk_live,
    output logic [NW*DW-1:0]  dom_image,
    output logic              dom_load,
    output logic              tk_reload,
    output logic              power_lost,
    output logic              if_unlocked
);
    localparam int unsigned IW = $clog2(NW);
    localparam int unsigned RW = $clog2(COMMIT_LAT + 3);

    logic [IW-1:0]         idx;
    rk_e                   kind;
    logic                  busy, apply, acc, trig_start, ctrl_ok, stage_we, clr_pk;
    logic                  prot_dirty_q, cfg_done_q, load_q, reload_q;
    logic [1:0]            cfg_w_q;
    logic [2:0]            tsel;
    logic [NW-1:0][DW-1:0] stage_w, dom_w;

    always_comb begin
        idx  = bus_addr[IW+1:2];
        kind = (bus_addr[AW-1:IW+2] == '0 && bus_addr[1:0] == 2'b00) ? reg_kind(idx) : RK_NONE;
        tsel = 3'(idx - 5'(IX_TIME0));
    end

    // write gating
    always_comb begin
        bus_wait   = bus_wr && busy && kind != RK_TRIG && kind != RK_NONE;
        acc        = bus_wr && !bus_wait;
        trig_start = acc && kind == RK_TRIG && bus_wdata == 32'd1 && !busy;
        ctrl_ok    = acc && kind == RK_CTRL && bus_wdata[15:8] == CTRL_KEY;
        clr_pk     = ctrl_ok && bus_wdata[4];
        unique case (kind)
            RK_GUARD, RK_TIME: stage_we = acc && if_unlocked;
            RK_PKEY:           stage_we = acc && cfg_done_q;
            RK_CFG, RK_PROT:   stage_we = acc;
            default:           stage_we = 1'b0;
        endcase
    end

    rtcf_commit_seq #(.LAT(COMMIT_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(trig_start), .busy(busy), .apply(apply)
    );

    rtcf_regfile #(.IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(stage_we), .wr_idx(idx),
        .wr_data(bus_wdata[DW-1:0]), .apply(apply), .clr_pk(clr_pk),
        .stage_o(stage_w), .dom_o(dom_w)
    );

    rtcf_unlock u_lock (
        .clk(clk), .rst_n(rst_n), .apply(apply), .dirty(prot_dirty_q),
        .val(stage_w[IX_PROT]), .open(if_unlocked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_dirty_q <= 1'b0;
            cfg_w_q      <= '0;
            cfg_done_q   <= 1'b0;
            load_q       <= 1'b0;
            reload_q     <= 1'b0;
        end else begin
            load_q   <= apply;
            reload_q <= ctrl_ok && bus_wdata[5];
            if (stage_we && kind == RK_PROT) prot_dirty_q <= 1'b1;
            else if (apply)                  prot_dirty_q <= 1'b0;
            if (stage_we && idx == IW'(IX_CFG0)) cfg_w_q[0] <= 1'b1;
            if (stage_we && idx == IW'(IX_CFG1)) cfg_w_q[1] <= 1'b1;
            if (apply && &cfg_w_q)               cfg_done_q <= 1'b1;
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (kind)
                RK_CTRL:          bus_rdata[6] = busy;
                RK_TIME:          bus_rdata[7:0] = tk_live[{tsel, 3'b000} +: 8];
                RK_NONE, RK_TRIG: bus_rdata = '0;
                default:          bus_rdata[DW-1:0] = stage_w[idx];
            endcase
        end
    end

    always_comb begin
        dom_image  = dom_w;
        dom_load   = load_q;
        tk_reload  = reload_q;
        power_lost = (dom_w[IX_PK1] != PK1_VAL) || (dom_w[IX_PK2] != PK2_VAL);
    end

    // checker: length of the current busy run
    logic [RW-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            busy_run_q <= '0;
        else if (!busy)                        busy_run_q <= '0;
        else if (busy_run_q != {RW{1'b1}})     busy_run_q <= busy_run_q + 1'b1;
    end

    a_r1_busy_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig_start |=> busy);
    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RW'(COMMIT_LAT + 1));
    a_r9_wait_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> busy);
    a_r9_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stage_w));
    a_r3_keyless_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == RK_CTRL && bus_wdata[15:8] != CTRL_KEY) |=> !tk_reload);
    a_r8_pkey_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == RK_PKEY && !cfg_done_q && !busy) |=> $stable(stage_w[IX_PK1]) && $stable(stage_w[IX_PK2]));
    a_r6_locked_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (kind == RK_GUARD || kind == RK_TIME) && !if_unlocked) |=> $stable(stage_w));
endmodule

// File: tb/sim_rtcf_commit_if.sv
`timescale 1ns/100ps
module sim_rtcf_commit_if;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait, dom_load, tk_reload, power_lost, if_unlocked;
    logic [55:0] tk_live = '0;
    logic [511:0] dom_image;

    int checks = 0, fails = 0;
    bit saw_wait;
    logic [15:0] exp_st [32];
    logic [15:0] exp_dm [32];

    always #2.5 clk = ~clk;

    rtcf_commit_if #(.COMMIT_LAT(LAT), .AW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .tk_live(tk_live), .dom_image(dom_image),
        .dom_load(dom_load), .tk_reload(tk_reload), .power_lost(power_lost),
        .if_unlocked(if_unlocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_time(int i);
        return i >= 5 && i <= 11;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; saw_wait = 1'b0;
        #0.5;
        while (bus_wait) begin
            saw_wait = 1'b1;
            @(negedge clk);
            #0.5;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic commit(input string req);
        logic [31:0] v;
        int n = 0;
        wr(8'h78, 32'd1);
        rd(8'h00, v);
        chk("R1 busy after trigger", {31'd0, v[6]}, 32'd1);
        for (int k = 0; k < 1000; k++) begin
            rd(8'h00, v);
            if (!v[6]) break;
            n++;
            @(negedge clk);
        end
        chk({req, " busy length"}, n, LAT + 1);
        chk({req, " load pulse"}, {31'd0, dom_load}, 32'd1);
        for (int i = 0; i < 32; i++) exp_dm[i] = exp_st[i];
    endtask

    task automatic chk_dom(input string req);
        for (int i = 0; i < 32; i++) chk(req, {16'd0, dom_image[i*16 +: 16]}, {16'd0, exp_dm[i]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, d;
        int g;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin exp_st[i] = '0; exp_dm[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        rd(8'h00, v);            chk("R11 busy", v, 32'd0);
        chk("R11 power_lost", {31'd0, power_lost}, 32'd1);
        chk("R11 unlocked", {31'd0, if_unlocked}, 32'd0);
        chk_dom("R11 image");

        // R6 guarded writes ignored while locked
        g = 12 + int'($urandom % 7);
        wr(8'(g * 4), $urandom);
        rd(8'(g * 4), v);        chk("R6 alarm locked", v, 32'd0);
        wr(8'h08, 32'hFFFF);
        rd(8'h08, v);            chk("R6 irqen locked", v, 32'd0);

        // R8 power keys before configuration
        wr(8'h4C, 32'hA357);
        rd(8'h4C, v);            chk("R8 pkey early", v, 32'd0);

        // R10 configuration readback, then commit (R1, R2)
        wr(8'h5C, 32'h4848);     exp_st[23] = 16'h4848;
        wr(8'h60, 32'hABCD0048); exp_st[24] = 16'h0048;
        rd(8'h5C, v);            chk("R10 cfg0 readback", v, 32'h4848);
        rd(8'h60, v);            chk("R10 cfg1 readback", v, 32'h0048);
        commit("R2 cfg");
        chk_dom("R2 image cfg");

        // R7/R8 power keys
        wr(8'h4C, 32'hA357);     exp_st[19] = 16'hA357;
        wr(8'h50, 32'h67D2);     exp_st[20] = 16'h67D2;
        rd(8'h50, v);            chk("R8 pkey accepted", v, 32'h67D2);
        chk("R7 uncommitted keys", {31'd0, power_lost}, 32'd1);
        commit("R2 pkey");
        chk("R7 keys committed", {31'd0, power_lost}, 32'd0);

        // R5 wrong first word, then K2 alone stays locked
        wr(8'h70, 32'h1234);     exp_st[28] = 16'h1234;
        commit("R2 prot");
        wr(8'h70, 32'h586A);     exp_st[28] = 16'h586A;
        commit("R2 prot");
        chk("R5 out of order", {31'd0, if_unlocked}, 32'd0);

        // R4 correct sequence
        wr(8'h70, 32'h9136);     exp_st[28] = 16'h9136;
        commit("R2 prot");
        chk("R4 half way", {31'd0, if_unlocked}, 32'd0);
        wr(8'h70, 32'h586A);     exp_st[28] = 16'h586A;
        commit("R2 prot");
        chk("R4 unlocked", {31'd0, if_unlocked}, 32'd1);

        // random guarded traffic (R6 accepted, R10 readback, R2 image)
        for (int r = 0; r < 24; r++) begin
            case ($urandom % 3)
                0: g = 2;
                1: g = 4;
                default: g = 5 + int'($urandom % 14);
            endcase
            d = $urandom;
            wr(8'(g * 4), d);
            exp_st[g] = d[15:0];
            if (!is_time(g)) begin
                rd(8'(g * 4), v);
                chk("R10 staged readback", v, {16'd0, d[15:0]});
            end
            if (r % 6 == 5) begin
                commit("R2 random");
                chk_dom("R2 image random");
            end
        end

        // R10 live time reads
        tk_live = {$urandom, $urandom};
        for (int k = 0; k < 7; k++) begin
            rd(8'(8'h14 + 8'(k * 4)), v);
            chk("R10 live time", v, {24'd0, tk_live[k*8 +: 8]});
        end

        // R9 write held during commit
        d = $urandom;
        wr(8'h78, 32'd1);
        wr(8'h34, d);
        chk("R9 wait seen", {31'd0, saw_wait}, 32'd1);
        rd(8'h00, v);            chk("R9 idle after hold", v, 32'd0);
        for (int i = 0; i < 32; i++) exp_dm[i] = exp_st[i];
        exp_st[13] = d[15:0];
        rd(8'h34, v);            chk("R9 held write kept", v, {16'd0, d[15:0]});
        chk_dom("R9 not in commit");

        // R1 wrong trigger value
        wr(8'h78, 32'd2);
        rd(8'h00, v);            chk("R1 bad trigger", v, 32'd0);

        // R3 control key
        wr(8'h00, 32'h0000_0030);
        chk("R3 keyless reload", {31'd0, tk_reload}, 32'd0);
        chk("R3 keyless clear", {31'd0, power_lost}, 32'd0);
        wr(8'h00, 32'h0000_4320);
        chk("R3 reload pulse", {31'd0, tk_reload}, 32'd1);
        chk("R3 reload only", {31'd0, power_lost}, 32'd0);
        wr(8'h00, 32'h0000_4310);
        chk("R3 clear keys", {31'd0, power_lost}, 32'd1);
        rd(8'h4C, v);            chk("R3 staged key cleared", v, 32'd0);
        exp_st[19] = '0; exp_st[20] = '0; exp_dm[19] = '0; exp_dm[20] = '0;
        chk_dom("R3 image after clear");

        // R5 restart while open, then R6 lock again
        wr(8'h70, 32'h9136);     exp_st[28] = 16'h9136;
        commit("R2 prot");
        chk("R5 restart while open", {31'd0, if_unlocked}, 32'd0);
        wr(8'h08, ~{16'd0, exp_st[2]});
        rd(8'h08, v);            chk("R6 relocked", v, {16'd0, exp_st[2]});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule